// File: doc/BRIEF.md
# Memory Write-Readback Pattern Checker

This block drives the user-side command and data channels of a DDR memory controller to test it. Once the controller reports that calibration has finished, the block writes a counting pattern to a run of consecutive burst addresses. It then idles for a fixed interval and reads the same run back. It compares every word the controller marks as valid against a local count of the words received so far. Any difference raises an error output, which stays set until reset.

The command channel carries an operation code and a byte-style address that steps by one burst per command. Write data travels on its own channel, separate from commands. The command counter and the write-data counter therefore move independently, and each moves only when its own handshake completes.

When a read pass finishes, the block goes back to its idle state. If calibration is still reported as done, it starts a new pass with its counters cleared. The error flag is not cleared by a new pass.

Top module: `mem_pattern_checker`

## Requirements
- R1: The reset input is asynchronous and active-low. Its release is synchronised through two flops. While reset is held, and for the first two clock edges after release, `cmd_en` and `wd_en` are 0 and `err` is 0.
- R2: The block leaves idle only when `calib_done` is 1. While `calib_done` stays 0, no command is issued and no write data is offered.
- R3: In the write phase, exactly N_WORDS write-data beats are transferred, carrying the values 0, 1, 2 … N_WORDS-1 in that order. `wd_end` equals `wd_en` on every cycle. The offered word holds steady until `wd_en` and `wd_rdy` are both 1, and no beat follows the last one.
- R4: In the write phase, exactly N_WORDS commands with code 3'b000 are accepted. Their addresses are 0, 8, 16 … in order, stepping by ADDR_STEP per accepted command. The address and code hold steady until `cmd_en` and `cmd_rdy` are both 1.
- R5: After the later of the last write-command acceptance and the last write-data acceptance, there is one cycle with no command, then WAIT_CYC cycles with no command. The first read command appears on the following cycle, WAIT_CYC+2 cycles after that last acceptance.
- R6: In the read phase, exactly N_WORDS commands with code 3'b001 are accepted, at addresses 0, 8, 16 … stepping by ADDR_STEP.
- R7: The read counter advances only on cycles where `rd_valid` is 1. Data presented while `rd_valid` is 0 has no effect on `err`.
- R8: A word returned with `rd_valid` at 1 whose value differs from the read counter sets `err` on the next cycle. This applies at any position, including the first and the last word.
- R9: `err` is sticky until reset. After N_WORDS valid words the block returns to idle. If `calib_done` is still 1, it then restarts at write address 0 with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calib_done | input | 1 | Controller reports calibration finished |
| cmd_en | output | 1 | Command valid |
| cmd_op | output | 3 | Command code, 3'b000 write, 3'b001 read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_rdy | input | 1 | Controller can take a command |
| wd_data | output | DATA_W | Write data word |
| wd_en | output | 1 | Write data valid |
| wd_end | output | 1 | Last beat of this burst's data |
| wd_rdy | input | 1 | Controller can take write data |
| rd_data | input | DATA_W | Read data word |
| rd_valid | input | 1 | Read data valid |
| err | output | 1 | Sticky mismatch flag |

## Verification
A fault in the state or counters shows at the ports within one cycle of the next handshake. A command counter that slips gives a wrong or repeated address on the next accepted command. A data counter that slips gives an out-of-order write value on the next accepted beat. A wait counter that is off changes the measured gap between the last write and the first read command. A read counter that is off, or a bad compare, shows as `err` rising or failing to rise one cycle after the affected valid word. It also shows as the block failing to return to idle and restart after exactly N_WORDS words.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0001,
    ST_WRITE = 4'b0010,
    ST_WAIT  = 4'b0100,
    ST_READ  = 4'b1000
  } mpc_state_e;

  localparam logic [2:0] OP_WRITE = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b001;
endpackage

// File: rtl/mpc_seq.sv
module mpc_seq
  import mpc_pkg::*;
#(
  parameter int WAIT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       calib_done,
  input  logic       wr_done,
  input  logic       rd_done,
  output mpc_state_e state
);
  localparam int WW = $clog2(WAIT_CYC + 1);

  mpc_state_e       state_nxt;
  logic [WW-1:0]    wait_cnt;
  logic             wait_last;
  logic             wait_run;

  assign wait_run  = (state == ST_WAIT);
  assign wait_last = wait_run && (wait_cnt == WW'(WAIT_CYC - 1));

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (calib_done) state_nxt = ST_WRITE;
      ST_WRITE: if (wr_done)    state_nxt = ST_WAIT;
      ST_WAIT:  if (wait_last)  state_nxt = ST_READ;
      ST_READ:  if (rd_done)    state_nxt = ST_IDLE;
      default:                  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wait_cnt <= '0;
    else if (!wait_run) wait_cnt <= '0;
    else               wait_cnt <= wait_cnt + 1'b1;
  end

  // R2: no departure from idle without calibration
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !calib_done) |=> (state == ST_IDLE));

  // R5: the read phase is entered only from the wait interval
  assert_read_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ && state_nxt == ST_READ) |-> (state == ST_WAIT));
endmodule

// File: rtl/mpc_gen.sv
module mpc_gen
  import mpc_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int DATA_W    = 32,
  parameter int N_WORDS   = 512,
  parameter int ADDR_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mpc_state_e        state,
  input  logic              cmd_rdy,
  input  logic              wd_rdy,
  output logic              cmd_en,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] wd_data,
  output logic              wd_en,
  output logic              wd_end,
  output logic              wr_done
);
  localparam int CW = $clog2(N_WORDS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(N_WORDS);

  logic [CW-1:0] cmd_cnt;
  logic [CW-1:0] wd_cnt;
  logic          in_wr, in_rd;
  logic          cmd_take, wd_take;
  logic          cmd_clr, wd_clr;

  assign in_wr    = (state == ST_WRITE);
  assign in_rd    = (state == ST_READ);
  assign cmd_en   = (in_wr || in_rd) && (cmd_cnt != CNT_FULL);
  assign cmd_op   = in_rd ? OP_READ : OP_WRITE;
  assign cmd_addr = ADDR_W'(cmd_cnt) * ADDR_W'(ADDR_STEP);
  assign wd_en    = in_wr && (wd_cnt != CNT_FULL);
  assign wd_end   = wd_en;
  assign wd_data  = DATA_W'(wd_cnt);
  assign wr_done  = in_wr && (cmd_cnt == CNT_FULL) && (wd_cnt == CNT_FULL);

  assign cmd_take = cmd_en && cmd_rdy;
  assign wd_take  = wd_en && wd_rdy;
  assign cmd_clr  = (state == ST_IDLE) || (state == ST_WAIT);
  assign wd_clr   = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_cnt <= '0;
    else if (cmd_clr)  cmd_cnt <= '0;
    else if (cmd_take) cmd_cnt <= cmd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wd_cnt <= '0;
    else if (wd_clr)  wd_cnt <= '0;
    else if (wd_take) wd_cnt <= wd_cnt + 1'b1;
  end

  // R4: a stalled command keeps its address and code
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_rdy) |=> (cmd_en && $stable(cmd_addr) && $stable(cmd_op)));

  // R3: a stalled write word keeps its value
  assert_wd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && !wd_rdy) |=> (wd_en && $stable(wd_data)));

  // R3: no offered word lies outside the pattern range
  assert_wd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |-> (wd_data < DATA_W'(N_WORDS)));
endmodule

// File: rtl/mpc_chk.sv
module mpc_chk
  import mpc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mpc_state_e        state,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              err
);
  localparam int CW = $clog2(N_WORDS + 1);

  logic [CW-1:0] rd_cnt;
  logic          in_rd;
  logic          beat;
  logic          miss;

  assign in_rd   = (state == ST_READ);
  assign beat    = in_rd && rd_valid;
  assign miss    = beat && (rd_data != DATA_W'(rd_cnt));
  assign rd_done = beat && (rd_cnt == CW'(N_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_cnt <= '0;
    else if (state == ST_IDLE)   rd_cnt <= '0;
    else if (beat)               rd_cnt <= rd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err <= 1'b0;
    else if (miss) err <= 1'b1;
  end

  // R7: the counter does not move without valid data
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && !rd_valid) |=> (rd_cnt == $past(rd_cnt)));

  // R8: a differing valid word raises the flag on the next cycle
  assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && rd_valid && rd_data != DATA_W'(rd_cnt)) |=> err);

  // R9: the flag never falls while out of reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/mem_pattern_checker.sv
module mem_pattern_checker
  import mpc_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int DATA_W    = 32,
  parameter int N_WORDS   = 512,
  parameter int ADDR_STEP = 8,
  parameter int WAIT_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              calib_done,
  output logic              cmd_en,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rdy,
  output logic [DATA_W-1:0] wd_data,
  output logic              wd_en,
  output logic              wd_end,
  input  logic              wd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              err
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  mpc_state_e state;
  logic       wr_done, rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mpc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .calib_done (calib_done),
    .wr_done    (wr_done),
    .rd_done    (rd_done),
    .state      (state)
  );

  mpc_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WORDS(N_WORDS), .ADDR_STEP(ADDR_STEP)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .state    (state),
    .cmd_rdy  (cmd_rdy),
    .wd_rdy   (wd_rdy),
    .cmd_en   (cmd_en),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .wd_data  (wd_data),
    .wd_en    (wd_en),
    .wd_end   (wd_end),
    .wr_done  (wr_done)
  );

  mpc_chk #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .state    (state),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_done  (rd_done),
    .err      (err)
  );

  // R1: nothing is offered while the synchronised reset is low
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!cmd_en && !wd_en && !err));
endmodule

// File: tb/sim_mem_pattern_checker.sv
module sim_mem_pattern_checker;
  localparam int AW = 28, DW = 32, NW = 512, STEP = 8, WC = 16;
  localparam int NV = 5;
  localparam int V_PCT  [NV] = '{100, 60, 35, 85, 50};
  localparam int V_LAT  [NV] = '{1, 3, 7, 2, 12};
  localparam int V_CORR [NV] = '{-1, -1, 0, 511, 200};

  logic clk = 1'b0;
  logic rst_n, calib;
  logic cmd_en, cmd_rdy, wd_en, wd_end, wd_rdy, rd_valid, err;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_data, rd_data;

  always #4 clk = ~clk;

  mem_pattern_checker #(.ADDR_W(AW), .DATA_W(DW), .N_WORDS(NW),
                        .ADDR_STEP(STEP), .WAIT_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .calib_done(calib),
    .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rdy(cmd_rdy),
    .wd_data(wd_data), .wd_en(wd_en), .wd_end(wd_end), .wd_rdy(wd_rdy),
    .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rdy_pct = 100, lat = 1, corrupt_idx = -1;
  bit record = 0;
  logic [DW-1:0] mem [NW];
  int wa [NW];
  logic [DW-1:0] wdv [NW];
  int q_addr [NW], q_due [NW];
  int q_wr, q_rd, wc_n, wd_n, rc_n, rv_n, paired;
  int addr_err_w, data_err_w, addr_err_r, end_err, bad_op;
  int last_wr_cyc, first_rd_en_cyc;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    q_wr = 0; q_rd = 0; wc_n = 0; wd_n = 0; rc_n = 0; rv_n = 0; paired = 0;
    addr_err_w = 0; data_err_w = 0; addr_err_r = 0; end_err = 0; bad_op = 0;
    last_wr_cyc = 0; first_rd_en_cyc = -1;
    for (int i = 0; i < NW; i++) mem[i] = '0;
  endtask

  // behavioural controller: ready and returns decided at the falling edge
  always @(negedge clk) begin
    cyc++;
    cmd_rdy = (($urandom % 100) < rdy_pct);
    wd_rdy  = (($urandom % 100) < rdy_pct);
    if (q_rd < q_wr && q_due[q_rd] <= cyc && (($urandom % 100) < rdy_pct)) begin
      rd_valid = 1'b1;
      rd_data  = mem[(q_addr[q_rd] / STEP) % NW] ^ ((rv_n == corrupt_idx) ? 32'd1 : 32'd0);
      q_rd++;
      rv_n++;
    end else begin
      rd_valid = 1'b0;
      rd_data  = $urandom;
    end
    #1;
    if (record) begin
      if (wd_end !== wd_en) end_err++;
      if (cmd_en && cmd_op == 3'b001 && first_rd_en_cyc < 0) first_rd_en_cyc = cyc;
      if (cmd_en && cmd_rdy) begin
        if (cmd_op == 3'b000) begin
          if (int'(cmd_addr) != wc_n * STEP) addr_err_w++;
          if (wc_n < NW) wa[wc_n] = int'(cmd_addr);
          wc_n++;
          last_wr_cyc = cyc;
        end else if (cmd_op == 3'b001) begin
          if (int'(cmd_addr) != rc_n * STEP) addr_err_r++;
          if (q_wr < NW) begin
            q_addr[q_wr] = int'(cmd_addr);
            q_due[q_wr]  = cyc + lat;
            q_wr++;
          end
          rc_n++;
        end else bad_op++;
      end
      if (wd_en && wd_rdy) begin
        if (wd_data != DW'(wd_n)) data_err_w++;
        if (wd_n < NW) wdv[wd_n] = wd_data;
        wd_n++;
        last_wr_cyc = cyc;
      end
      while (paired < wc_n && paired < wd_n && paired < NW) begin
        mem[(wa[paired] / STEP) % NW] = wdv[paired];
        paired++;
      end
    end
  end

  task automatic do_reset();
    record = 0; calib = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one full pass; returns one cycle after the last valid word was consumed
  task automatic do_pass(int pct, int l, int cidx, bit exp_err, string tag);
    int guard;
    do_reset();
    clear_model();
    rdy_pct = pct; lat = l; corrupt_idx = cidx;
    @(negedge clk); #2;
    record = 1; calib = 1'b1;
    guard = 0;
    while (rv_n < NW && guard < 60000) begin
      @(negedge clk); #2;
      guard++;
    end
    @(negedge clk); #2;
    record = 0;
    check(wc_n == NW, {"R4 write cmd count ", tag}, wc_n, NW);
    check(addr_err_w == 0, {"R4 write addr sequence ", tag}, addr_err_w, 0);
    check(wd_n == NW, {"R3 write beat count ", tag}, wd_n, NW);
    check(data_err_w == 0 && end_err == 0, {"R3 write data order/end ", tag},
          data_err_w + end_err, 0);
    check(rc_n == NW && bad_op == 0, {"R6 read cmd count ", tag}, rc_n, NW);
    check(addr_err_r == 0, {"R6 read addr sequence ", tag}, addr_err_r, 0);
    check(first_rd_en_cyc - last_wr_cyc == WC + 2, {"R5 write-to-read gap ", tag},
          first_rd_en_cyc - last_wr_cyc, WC + 2);
    check(err == exp_err, exp_err ? {"R8 mismatch flagged ", tag}
                                  : {"R7 clean readback, invalid junk ignored ", tag},
          int'(err), int'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cmd_rdy = 1'b0; wd_rdy = 1'b0; rd_valid = 1'b0; rd_data = '0;
    clear_model();

    // R1: reset held with calibration already high
    calib = 1'b1; rst_n = 1'b0;
    repeat (4) @(negedge clk); #2;
    check(!cmd_en && !wd_en && !err, "R1 outputs quiet in reset",
          int'({cmd_en, wd_en, err}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    check(!cmd_en, "R1 quiet after first edge past release", int'(cmd_en), 0);
    @(negedge clk); #2;
    check(!cmd_en, "R1 quiet after second edge past release", int'(cmd_en), 0);
    @(negedge clk); #2;
    check(cmd_en && cmd_op == 3'b000 && cmd_addr == '0, "R2 start once calibrated",
          int'(cmd_en), 1);

    // R2: without calibration nothing moves
    do_reset();
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #2;
        if (cmd_en || wd_en) seen++;
      end
      check(seen == 0, "R2 idle while calibration low", seen, 0);
    end

    // table of passes: ready percent, latency, corrupted index
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("vec%0d", v);
      do_pass(V_PCT[v], V_LAT[v], V_CORR[v], V_CORR[v] >= 0, tag);
    end

    // R9: sticky flag and automatic restart
    do_pass(70, 4, 5, 1'b1, "sticky");
    @(negedge clk); #2;
    check(cmd_en && cmd_op == 3'b000 && cmd_addr == '0, "R9 restart write at address 0",
          int'(cmd_addr), 0);
    check(wd_en && wd_data == '0, "R9 restart data at 0", int'(wd_data), 0);
    check(err == 1'b1, "R9 flag kept across restart", int'(err), 1);
    repeat (300) @(negedge clk);
    #2;
    check(err == 1'b1, "R9 flag still set later", int'(err), 1);
    rst_n = 1'b0;
    @(negedge clk); #2;
    check(err == 1'b0, "R9 flag cleared by reset", int'(err), 0);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule